// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a 16 KB data cache holding 128 sets of four 32-byte lines. A processor-side port takes one word request at a time: a read or a byte-masked write. A memory-side port moves whole lines, either as a victim writeback or as a line fill. Each request is looked up against all four ways of its set. A hit is answered from the cache. A write hit changes only the selected bytes and marks the line dirty, so memory sees the data only when that line is later evicted.

On a miss the block picks a way. A way that holds no valid line is always taken first. When every way is valid, a three-bit binary tree per set chooses the least recently pointed-at way. If the chosen line is dirty, it is written out in full before the new line is requested. The processor response is held until the fill arrives. Line data lives in eight word-wide banks, one per 4-byte word of a line, so a word access touches exactly one bank.

The block serves one request at a time. Its memory port uses a valid/ready request handshake and a single-cycle return strobe that carries the whole line.

Top module: `wb_assoc_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req_valid is 0. No line is valid, so the first access to any address misses.
- R2: A request address splits into three fields. Bits [4:2] select the word, and so the bank. Bits [11:5] select the set. Bits [31:12] form the tag. The same tag in a different set is a different line.
- R3: A read hit raises resp_valid for one cycle, on the clock edge after the acceptance edge, with the stored word. It makes no memory request.
- R4: A write hit changes only the bytes whose req_be bit is set (bit i guards bits 8i+7:8i) and marks the line dirty.
- R5: A miss into a set with a free way issues exactly one read request, whose address is the line address with the low 5 bits cleared. It makes no write request. The response carries the filled word.
- R6: Invalid ways are filled before any replacement. Four distinct tags in one set all allocate without eviction and then all hit.
- R7: With all four ways valid, the victim comes from a three-bit tree per set. The root bit picks the pair: 0 picks ways 0/1 and 1 picks ways 2/3. The left pair bit picks way 0 on 0 and way 1 on 1. The right pair bit picks way 2 on 0 and way 3 on 1. Every hit and every fill sets the bits on the accessed way's path to point away from it. The reset state is all zeros.
- R8: A dirty victim is sent as a write request carrying the victim's line address and its full line. That request is accepted before the read request for the new line. The data written back is what a later fill returns.
- R9: A clean victim is dropped with no write request.
- R10: A write miss allocates the line, merges the enabled bytes into the filled data and marks the line dirty.
- R11: On mem_wdata and mem_rdata, the word at line offset 4k occupies bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Word at the request address after the access |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = writeback, 0 = fill read |
| mem_req_addr | output | 32 | Line address, low 5 bits zero |
| mem_wdata | output | 256 | Writeback line |
| mem_rvalid | input | 1 | Fill data strobe |
| mem_rdata | input | 256 | Fill line |

## Verification
A hit answers on the clock edge after the acceptance edge. The bench records the cycle count at the falling edge that follows acceptance and requires the response exactly one count later for every access it predicts to hit. A miss answers one edge after the fill strobe is sampled, so the bench only requires a miss response to come later than a hit would. What it pins for a miss is the order and content of the memory transactions: each handshake is compared, in arrival order, against writeback and fill entries queued by hand from the tree-state walk. Every output is sampled on falling edges, half a cycle clear of the registers that drive it.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam int TREE_W = WAYS - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WBACK, ST_FILLREQ, ST_FILLWAIT
  } cstate_t;

  // tree bit 0: pair select, bit 1: inside ways 0/1, bit 2: inside ways 2/3
  function automatic logic [WAY_W-1:0] tree_pick(input logic [TREE_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < BE_W; i++)
      r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wb_cache_bank.sv
module wb_cache_bank
  import wb_cache_pkg::*;
#(
  parameter int SETS  = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int ROW_W = WAYS * WORD_W,
  localparam int ROW_B = WAYS * BE_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ROW_W-1:0] rd_row,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_B-1:0] wr_be,
  input  logic [ROW_W-1:0] wr_row
);
  logic [ROW_W-1:0] ram [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < ROW_B; b++)
        if (wr_be[b]) ram[wr_idx][8*b +: 8] <= wr_row[8*b +: 8];
    end
    if (rd_en) rd_row <= ram[rd_idx];
  end
endmodule

// File: rtl/wb_cache_tags.sv
module wb_cache_tags
  import wb_cache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [WAYS*TAG_W-1:0] rd_tags,
  input  logic [IDX_W-1:0]      cur_idx,
  output logic [WAYS-1:0]       cur_valid,
  output logic [WAYS-1:0]       cur_dirty,
  input  logic                  fill_en,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  fill_dirty,
  input  logic                  mark_en,
  input  logic [WAY_W-1:0]      mark_way
);
  logic [WAYS-1:0] vld [SETS];
  logic [WAYS-1:0] drt [SETS];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tram [SETS];
      always_ff @(posedge clk) begin
        if (fill_en && fill_way == WAY_W'(w)) tram[cur_idx] <= fill_tag;
        if (rd_en) rd_tags[w*TAG_W +: TAG_W] <= tram[rd_idx];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        drt[s] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld[cur_idx][fill_way] <= 1'b1;
        drt[cur_idx][fill_way] <= fill_dirty;
      end
      if (mark_en) drt[cur_idx][mark_way] <= 1'b1;
    end
  end

  assign cur_valid = vld[cur_idx];
  assign cur_dirty = drt[cur_idx];
endmodule

// File: rtl/wb_cache_plru.sv
module wb_cache_plru
  import wb_cache_pkg::*;
#(
  parameter int SETS  = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  logic [TREE_W-1:0] tree [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (touch_en) begin
      tree[idx] <= tree_touch(tree[idx], touch_way);
    end
  end

  assign victim = tree_pick(tree[idx]);
endmodule

// File: rtl/wb_assoc_cache.sv
module wb_assoc_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS       = 128,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFFS_W = WSEL_W + 2,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W,
  localparam int LINE_W = LINE_WORDS * WORD_W,
  localparam int ROW_W  = WAYS * WORD_W,
  localparam int ROW_B  = WAYS * BE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata
);
  cstate_t            state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;
  logic [WAY_W-1:0]   vic_q;

  logic               accept;
  logic [IDX_W-1:0]   rd_idx, set_q;
  logic [TAG_W-1:0]   tag_q;
  logic [WSEL_W-1:0]  word_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_idx    = req_addr[OFFS_W +: IDX_W];
  assign set_q     = addr_q[OFFS_W +: IDX_W];
  assign tag_q     = addr_q[ADDR_W-1 -: TAG_W];
  assign word_q    = addr_q[2 +: WSEL_W];

  // ---------------- tag, state and replacement stores ----------------
  logic [WAYS*TAG_W-1:0] tags_rd;
  logic [WAYS-1:0]       way_valid, way_dirty;
  logic                  fill_now, mark_now, touch_now;
  logic [WAY_W-1:0]      touch_way, tree_vic;

  wb_cache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_idx(rd_idx), .rd_tags(tags_rd),
    .cur_idx(set_q), .cur_valid(way_valid), .cur_dirty(way_dirty),
    .fill_en(fill_now), .fill_way(vic_q), .fill_tag(tag_q), .fill_dirty(wr_q),
    .mark_en(mark_now), .mark_way(touch_way)
  );

  wb_cache_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst(rst), .idx(set_q), .victim(tree_vic),
    .touch_en(touch_now), .touch_way(touch_way)
  );

  // ---------------- hit detection and victim choice ----------------
  logic [WAYS-1:0]  hit_vec;
  logic             hit, any_free;
  logic [WAY_W-1:0] hit_way, free_way, victim;

  always_comb begin
    hit_vec  = '0;
    hit_way  = '0;
    free_way = '0;
    any_free = 1'b0;
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = way_valid[w] && (tags_rd[w*TAG_W +: TAG_W] == tag_q);
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!way_valid[w]) begin
        free_way = WAY_W'(w);
        any_free = 1'b1;
      end
    end
    hit    = |hit_vec;
    victim = any_free ? free_way : tree_vic;
  end

  assign fill_now  = (state_q == ST_FILLWAIT) && mem_rvalid;
  assign mark_now  = (state_q == ST_LOOKUP) && hit && wr_q;
  assign touch_now = ((state_q == ST_LOOKUP) && hit) || fill_now;
  assign touch_way = fill_now ? vic_q : hit_way;

  // ---------------- banked data array ----------------
  logic [ROW_W-1:0]  bank_q  [LINE_WORDS];
  logic              bank_we [LINE_WORDS];
  logic [ROW_B-1:0]  bank_be [LINE_WORDS];
  logic [ROW_W-1:0]  bank_wd [LINE_WORDS];
  logic [LINE_W-1:0] vic_line;
  logic [WORD_W-1:0] hit_word, fill_word;

  always_comb begin
    for (int b = 0; b < LINE_WORDS; b++) begin
      logic [WORD_W-1:0] fw;
      fw = mem_rdata[b*WORD_W +: WORD_W];
      if (wr_q && word_q == WSEL_W'(b)) fw = byte_merge(fw, wdata_q, be_q);
      bank_we[b] = 1'b0;
      bank_be[b] = '0;
      bank_wd[b] = '0;
      if (mark_now && word_q == WSEL_W'(b)) begin
        bank_we[b] = 1'b1;
        bank_be[b][hit_way*BE_W +: BE_W] = be_q;
        bank_wd[b] = {WAYS{wdata_q}};
      end else if (fill_now) begin
        bank_we[b] = 1'b1;
        bank_be[b][vic_q*BE_W +: BE_W] = '1;
        bank_wd[b] = {WAYS{fw}};
      end
      vic_line[b*WORD_W +: WORD_W] = bank_q[b][victim*WORD_W +: WORD_W];
    end
    hit_word  = bank_q[word_q][hit_way*WORD_W +: WORD_W];
    fill_word = mem_rdata[word_q*WORD_W +: WORD_W];
  end

  generate
    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
      wb_cache_bank #(.SETS(SETS)) u_bank (
        .clk(clk), .rd_en(accept), .rd_idx(rd_idx), .rd_row(bank_q[b]),
        .wr_en(bank_we[b]), .wr_idx(set_q), .wr_be(bank_be[b]), .wr_row(bank_wd[b])
      );
    end
  endgenerate

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      resp_valid    <= 1'b0;
      resp_rdata    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_wdata     <= '0;
      addr_q        <= '0;
      wr_q          <= 1'b0;
      wdata_q       <= '0;
      be_q          <= '0;
      vic_q         <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit) begin
          resp_valid <= 1'b1;
          resp_rdata <= wr_q ? byte_merge(hit_word, wdata_q, be_q) : hit_word;
          state_q    <= ST_IDLE;
        end else begin
          vic_q         <= victim;
          mem_req_valid <= 1'b1;
          if (way_valid[victim] && way_dirty[victim]) begin
            mem_req_write <= 1'b1;
            mem_req_addr  <= {tags_rd[victim*TAG_W +: TAG_W], set_q, OFFS_W'(0)};
            mem_wdata     <= vic_line;
            state_q       <= ST_WBACK;
          end else begin
            mem_req_write <= 1'b0;
            mem_req_addr  <= {tag_q, set_q, OFFS_W'(0)};
            state_q       <= ST_FILLREQ;
          end
        end
        ST_WBACK: if (mem_req_ready) begin
          mem_req_write <= 1'b0;
          mem_req_addr  <= {tag_q, set_q, OFFS_W'(0)};
          state_q       <= ST_FILLREQ;
        end
        ST_FILLREQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state_q       <= ST_FILLWAIT;
        end
        ST_FILLWAIT: if (mem_rvalid) begin
          resp_valid <= 1'b1;
          resp_rdata <= wr_q ? byte_merge(fill_word, wdata_q, be_q) : fill_word;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_assoc_cache_chk.sv
module wb_assoc_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  // R1: quiet, ready state right after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !resp_valid && !mem_req_valid));

  // R3: the response strobe lasts one cycle
  a_r3_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R3: an accepted request blocks the next one
  a_r3_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R5: no memory traffic while waiting for a new request
  a_r5_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  // R8: a pending memory request holds still
  a_r8_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R8: a writeback is followed directly by the fill read
  a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (mem_req_valid && !mem_req_write));
endmodule

bind wb_assoc_cache wb_assoc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr)
);

// File: tb/wb_assoc_cache_test.sv
module wb_assoc_cache_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic         req_ready, resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic         mem_req_ready = 1'b1;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_wdata;
  logic         mem_rvalid = 1'b0;
  logic [255:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wb_assoc_cache uut (.*);

  int cyc = 0, checks = 0, fails = 0, resp_seen = 0, acc_cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] refm [logic [31:0]];   // program view
  logic [31:0] memw [logic [31:0]];   // backing memory

  logic [31:0] e_data[$]; bit e_hit[$]; string e_req[$];
  bit m_wr[$]; logic [31:0] m_addr[$]; logic [255:0] m_data[$]; string m_req[$];

  function automatic logic [31:0] seed(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction
  function automatic logic [31:0] rword(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed(a);
  endfunction
  function automatic logic [31:0] mword(input logic [31:0] a);
    return memw.exists(a) ? memw[a] : seed(a);
  endfunction
  function automatic logic [31:0] adr(input int tag, input int set, input int word);
    return {tag[19:0], set[6:0], word[2:0], 2'b00};
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic exp_wb(input logic [31:0] line, input string rq);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[32*k +: 32] = rword(line + 32'(4*k));  // R11 layout
    m_wr.push_back(1); m_addr.push_back(line); m_data.push_back(d); m_req.push_back(rq);
  endtask
  task automatic exp_fill(input logic [31:0] line, input string rq);
    m_wr.push_back(0); m_addr.push_back(line); m_data.push_back('0); m_req.push_back(rq);
  endtask

  // driver: one request, expected result queued first
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input bit hit, input string rq);
    int target;
    if (wr) refm[a] = merge(rword(a), wd, be);
    e_data.push_back(rword(a)); e_hit.push_back(hit); e_req.push_back(rq);
    target = resp_seen + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 0;
    while (resp_seen < target) @(negedge clk);
  endtask

  // response monitor
  initial forever begin
    @(negedge clk);
    if (resp_valid) begin
      if (e_data.size() == 0) begin
        check(0, "R3 unexpected response", resp_rdata, 0);
      end else begin
        logic [31:0] ed; bit eh; string rq;
        ed = e_data.pop_front(); eh = e_hit.pop_front(); rq = e_req.pop_front();
        check(resp_rdata == ed, {rq, " data"}, resp_rdata, ed);
        if (eh) check(cyc - acc_cyc == 1, {rq, " R3 hit latency"}, cyc - acc_cyc, 1);
        else    check(cyc - acc_cyc > 1, {rq, " miss latency"}, cyc - acc_cyc, 2);
      end
      resp_seen++;
    end
  end

  // memory model and transaction monitor (ready is always high)
  initial forever begin
    @(negedge clk);
    if (!rst && mem_req_valid) begin
      bit w; logic [31:0] a; logic [255:0] d;
      w = mem_req_write; a = mem_req_addr; d = mem_wdata;
      if (m_wr.size() == 0) begin
        check(0, "R3 R9 unexpected memory request", {w, a}, 0);
      end else begin
        bit ew; logic [31:0] ea; logic [255:0] edt; string rq;
        ew = m_wr.pop_front(); ea = m_addr.pop_front(); edt = m_data.pop_front();
        rq = m_req.pop_front();
        check(w == ew && a == ea, {rq, " mem kind/addr"}, {w, a}, {ew, ea});
        if (ew && w) check(d == edt, {rq, " R11 writeback line"}, d, edt);
      end
      @(posedge clk);
      if (w) begin
        for (int k = 0; k < 8; k++) memw[a + 32'(4*k)] = d[32*k +: 32];
      end else begin
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) mem_rdata[32*k +: 32] = mword(a + 32'(4*k));
        mem_rvalid = 1;
        @(negedge clk);
        mem_rvalid = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1 reset state",
          {req_ready, resp_valid, mem_req_valid}, 3'b100);

    exp_fill(adr(1, 3, 0), "R5");
    access(0, adr(1, 3, 5), 0, 0, 0, "R1");                   // cold miss
    access(0, adr(1, 3, 5), 0, 0, 1, "R3");
    access(0, adr(1, 3, 0), 0, 0, 1, "R2");                   // other bank, same line
    access(1, adr(1, 3, 5), 32'hDEADBEEF, 4'b0101, 1, "R4");
    access(0, adr(1, 3, 5), 0, 0, 1, "R4");
    access(1, adr(1, 3, 7), 32'hCAFEF00D, 4'b1000, 1, "R4");
    access(0, adr(1, 3, 7), 0, 0, 1, "R4");
    exp_fill(adr(1, 4, 0), "R2");
    access(0, adr(1, 4, 5), 0, 0, 0, "R2");                   // same tag, other set

    for (int t = 2; t <= 4; t++) begin
      exp_fill(adr(t, 3, 0), "R6");
      access(0, adr(t, 3, 1), 0, 0, 0, "R6");
    end
    for (int t = 1; t <= 4; t++) access(0, adr(t, 3, 5), 0, 0, 1, "R6");

    // tree now 000 -> way 0 (tag 1, dirty)
    exp_wb(adr(1, 3, 0), "R8");
    exp_fill(adr(5, 3, 0), "R8");
    access(0, adr(5, 3, 1), 0, 0, 0, "R7");
    access(0, adr(2, 3, 0), 0, 0, 1, "R7");
    // victim way 2 (tag 3, clean)
    exp_fill(adr(6, 3, 0), "R9");
    access(0, adr(6, 3, 2), 0, 0, 0, "R9");
    exp_fill(adr(3, 3, 0), "R7");
    access(0, adr(3, 3, 4), 0, 0, 0, "R7");                   // replaces way 0 (tag 5)

    // write miss into way 3 (tag 4, clean)
    exp_fill(adr(7, 3, 0), "R10");
    access(1, adr(7, 3, 2), 32'h12345678, 4'b1100, 0, "R10");
    access(0, adr(7, 3, 2), 0, 0, 1, "R10");
    access(0, adr(2, 3, 3), 0, 0, 1, "R7");
    access(0, adr(6, 3, 3), 0, 0, 1, "R7");
    access(0, adr(3, 3, 3), 0, 0, 1, "R7");
    // victim way 3 (tag 7, dirty from the write miss)
    exp_wb(adr(7, 3, 0), "R10");
    exp_fill(adr(8, 3, 0), "R8");
    access(0, adr(8, 3, 6), 0, 0, 0, "R11");
    // tag 1 line comes back from memory with its earlier writes
    exp_fill(adr(1, 3, 0), "R8");
    access(0, adr(1, 3, 5), 0, 0, 0, "R8");
    access(0, adr(1, 3, 7), 0, 0, 1, "R8");

    repeat (4) @(negedge clk);
    check(m_wr.size() == 0 && e_data.size() == 0, "R8 all expected transactions seen",
          m_wr.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule